// File: doc/BRIEF.md
# Profiling Overhead Counter Bank

This block holds five small profiling counters that sort every core cycle by its stall cause. Each cycle the core reports how many instructions retired, and whether a load-store operation, an exception entry or exit, or a low-power sleep is in progress. The cycle is charged to at most one of four stall counters: base instruction overhead, exception, load-store or sleep. A fifth counter adds up the extra instructions retired in cycles that retire more than one. Each counter has its own enable bit. All of them are also gated by a global trace enable and by a debug-observation permission input. Software can load any counter directly.

The bank also keeps a program-counter sample register. It returns an all-ones sentinel whenever no trustworthy sample exists. Each counter raises a one-cycle overflow pulse when it wraps. Counters are presented as 32-bit read values whose upper bits are zero.

Top module: `prof_ovh_bank`

## Requirements
- R1: After reset every counter reads 0, every overflow pulse is 0 and the PC sample reads all ones (0xFFFFFFFF).
- R2: A counter changes only on a cycle where its own enable bit, `trace_en` and `debug_ok` are all 1, unless software writes it. Enable bit positions are: bit 0 instruction overhead, bit 1 exception, bit 2 sleep, bit 3 load-store, bit 4 folded.
- R3: The instruction-overhead counter adds 1 on a cycle where `insn_cnt` is 0 and `lsu_busy`, `exc_busy` and `sleeping` are all 0.
- R4: The exception counter adds 1 on a cycle where `insn_cnt` is 0 and `exc_busy` is 1, whatever the values of `lsu_busy` and `sleeping`.
- R5: The load-store counter adds 1 on a cycle where `insn_cnt` is 0, `exc_busy` is 0 and `lsu_busy` is 1, whatever the value of `sleeping`.
- R6: The sleep counter adds 1 on a cycle where `insn_cnt` is 0, `lsu_busy` and `exc_busy` are 0 and `sleeping` is 1.
- R7: The folded counter adds `insn_cnt` minus 1 on a cycle where `insn_cnt` is at least 2. It holds when `insn_cnt` is 0 or 1.
- R8: A counter wraps modulo 256. The cycle its value shows the wrapped result, the matching `ovf_pulse` bit is 1 for one cycle. This includes a folded add that crosses 255 by more than one.
- R9: When `wr_en[i]` is 1, counter i takes `wr_data` on the next cycle and raises no overflow pulse, even if an increment was qualified in that cycle. Bits 31:8 of every counter output read 0.
- R10: One cycle after a cycle with `halted` = 1, `trace_en` = 0, `debug_ok` = 0 or `pc_valid` = 0, the PC sample reads all ones.
- R11: Otherwise, one cycle later the PC sample reads `pc_addr` with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Global trace enable |
| debug_ok | input | 1 | Debug observation permitted |
| halted | input | 1 | Core halted in debug |
| insn_cnt | input | INSN_W | Instructions retired this cycle |
| lsu_busy | input | 1 | Load-store operation in progress |
| exc_busy | input | 1 | Exception entry or exit in progress |
| sleeping | input | 1 | Core in power-saving mode |
| en_mask | input | 5 | Per-counter enables (see R2) |
| wr_en | input | 5 | Per-counter software write strobes |
| wr_data | input | CNT_W | Software write value |
| pc_valid | input | 1 | A recent instruction address is available |
| pc_addr | input | ADDR_W | Recent instruction address |
| cnt_ovh | output | RD_W | Instruction-overhead counter |
| cnt_exc | output | RD_W | Exception counter |
| cnt_slp | output | RD_W | Sleep counter |
| cnt_lsu | output | RD_W | Load-store counter |
| cnt_fld | output | RD_W | Folded-instruction counter |
| ovf_pulse | output | 5 | Per-counter wrap pulse, same bit order as en_mask |
| pc_sample | output | ADDR_W | PC sample or all-ones sentinel |

## Verification
The assertions assume that every input is known (0 or 1) after reset and that `insn_cnt` never exceeds the counter range. The stimulus draws each status flag and the instruction count from a seeded generator, so every combination of the qualification inputs shows up, including the overlapping stall causes. Software writes are kept rare, so long runs of increments occur and counters wrap on their own. Directed sequences place a counter just below 255 before a single or multi-count add, and issue a write in the same cycle as a qualified increment.

// File: rtl/prof_ovh_bank.sv
module prof_ovh_bank #(
  parameter int CNT_W  = 8,
  parameter int RD_W   = 32,
  parameter int INSN_W = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              debug_ok,
  input  logic              halted,
  input  logic [INSN_W-1:0] insn_cnt,
  input  logic              lsu_busy,
  input  logic              exc_busy,
  input  logic              sleeping,
  input  logic [4:0]        en_mask,
  input  logic [4:0]        wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              pc_valid,
  input  logic [ADDR_W-1:0] pc_addr,
  output logic [RD_W-1:0]   cnt_ovh,
  output logic [RD_W-1:0]   cnt_exc,
  output logic [RD_W-1:0]   cnt_slp,
  output logic [RD_W-1:0]   cnt_lsu,
  output logic [RD_W-1:0]   cnt_fld,
  output logic [4:0]        ovf_pulse,
  output logic [ADDR_W-1:0] pc_sample
);
  localparam int NCNT = 5;

  logic [CNT_W-1:0] cnt_q [NCNT];
  logic [CNT_W:0]   sum   [NCNT];
  logic [CNT_W-1:0] amt   [NCNT];
  logic [NCNT-1:0]  qual;
  logic [NCNT-1:0]  ovf_q;
  logic [ADDR_W-1:0] pc_q;

  wire gate = trace_en & debug_ok;
  wire idle = (insn_cnt == '0);

  assign qual[0] = gate & en_mask[0] & idle & ~lsu_busy & ~exc_busy & ~sleeping;
  assign qual[1] = gate & en_mask[1] & idle & exc_busy;
  assign qual[2] = gate & en_mask[2] & idle & ~lsu_busy & ~exc_busy & sleeping;
  assign qual[3] = gate & en_mask[3] & idle & ~exc_busy & lsu_busy;
  assign qual[4] = gate & en_mask[4] & (insn_cnt >= INSN_W'(2));

  always_comb begin
    for (int i = 0; i < NCNT; i++) begin
      amt[i] = (i == 4) ? (CNT_W'(insn_cnt) - CNT_W'(1)) : CNT_W'(1);
      sum[i] = {1'b0, cnt_q[i]} + {1'b0, amt[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) cnt_q[i] <= '0;
      ovf_q <= '0;
    end else begin
      for (int i = 0; i < NCNT; i++) begin
        if (wr_en[i]) begin
          cnt_q[i] <= wr_data;
          ovf_q[i] <= 1'b0;
        end else if (qual[i]) begin
          cnt_q[i] <= sum[i][CNT_W-1:0];
          ovf_q[i] <= sum[i][CNT_W];
        end else begin
          ovf_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '1;
    else if (halted | ~gate | ~pc_valid)
      pc_q <= '1;
    else
      pc_q <= pc_addr & ~ADDR_W'(1);
  end

  assign cnt_ovh   = RD_W'(cnt_q[0]);
  assign cnt_exc   = RD_W'(cnt_q[1]);
  assign cnt_slp   = RD_W'(cnt_q[2]);
  assign cnt_lsu   = RD_W'(cnt_q[3]);
  assign cnt_fld   = RD_W'(cnt_q[4]);
  assign ovf_pulse = ovf_q;
  assign pc_sample = pc_q;

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && wr_en == '0) |=> ($stable(cnt_ovh) && $stable(cnt_exc) && $stable(cnt_slp) && $stable(cnt_lsu) && $stable(cnt_fld))); // R2
  AST_ONE_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> ($countones({!$stable(cnt_ovh), !$stable(cnt_exc), !$stable(cnt_slp), !$stable(cnt_lsu)}) <= 1)); // R3
  AST_FOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_cnt < INSN_W'(2) && !wr_en[4]) |=> $stable(cnt_fld)); // R7
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse[0] |-> (cnt_ovh == '0)); // R8
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse[1] && !qual[1]) |=> !ovf_pulse[1]); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> (cnt_ovh == RD_W'($past(wr_data)) && !ovf_pulse[0])); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fld[RD_W-1:CNT_W] == '0 && cnt_lsu[RD_W-1:CNT_W] == '0)); // R9
  AST_PC_SENTINEL: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || !trace_en || !debug_ok || !pc_valid) |=> (pc_sample == '1)); // R10
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sample != '1) |-> (pc_sample[0] == 1'b0)); // R11
endmodule

// File: tb/tb_prof_ovh_bank.sv
module tb_prof_ovh_bank;
  logic clk = 0, rst_n = 0;
  logic tr, dbg, hlt, lsu, exc, slp, pv;
  logic [1:0] ic;
  logic [4:0] en, we;
  logic [7:0] wd;
  logic [31:0] pa;
  logic [31:0] c_ovh, c_exc, c_slp, c_lsu, c_fld, pcs;
  logic [4:0] ovf;

  int checks = 0, fails = 0;
  logic [7:0] m [5];
  logic [4:0] mo;
  logic [31:0] mpc;

  always #10 clk = ~clk;

  prof_ovh_bank dut (
    .clk(clk), .rst_n(rst_n), .trace_en(tr), .debug_ok(dbg), .halted(hlt),
    .insn_cnt(ic), .lsu_busy(lsu), .exc_busy(exc), .sleeping(slp),
    .en_mask(en), .wr_en(we), .wr_data(wd), .pc_valid(pv), .pc_addr(pa),
    .cnt_ovh(c_ovh), .cnt_exc(c_exc), .cnt_slp(c_slp), .cnt_lsu(c_lsu),
    .cnt_fld(c_fld), .ovf_pulse(ovf), .pc_sample(pcs));

  function automatic logic [31:0] dut_cnt(int i);
    case (i)
      0: return c_ovh;
      1: return c_exc;
      2: return c_slp;
      3: return c_lsu;
      default: return c_fld;
    endcase
  endfunction

  function automatic logic qualifies(int i);
    logic g, z;
    g = tr & dbg & en[i];
    z = (ic == 0);
    case (i)
      0: return g & z & !lsu & !exc & !slp;
      1: return g & z & exc;
      2: return g & z & !lsu & !exc & slp;
      3: return g & z & !exc & lsu;
      default: return g & (ic >= 2);
    endcase
  endfunction

  function automatic logic [31:0] pc_expect();
    if (hlt || !tr || !dbg || !pv) return 32'hFFFF_FFFF;
    return {pa[31:1], 1'b0};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic [8:0] s;
    for (int i = 0; i < 5; i++) begin
      if (we[i]) begin m[i] = wd; mo[i] = 0; end
      else if (qualifies(i)) begin
        s = {1'b0, m[i]} + ((i == 4) ? 9'(ic) - 9'd1 : 9'd1);
        m[i] = s[7:0]; mo[i] = s[8];
      end else mo[i] = 0;
    end
    mpc = pc_expect();
    @(posedge clk);
    @(negedge clk);
    check("R3 overhead counter", c_ovh, {24'h0, m[0]});
    check("R4 exception counter", c_exc, {24'h0, m[1]});
    check("R6 sleep counter", c_slp, {24'h0, m[2]});
    check("R5 load-store counter", c_lsu, {24'h0, m[3]});
    check("R7 folded counter", c_fld, {24'h0, m[4]});
    check("R8 overflow pulses", {27'h0, ovf}, {27'h0, mo});
    if (mpc == 32'hFFFF_FFFF) check("R10 pc sentinel", pcs, mpc);
    else check("R11 pc sample", pcs, mpc);
  endtask

  task automatic quiet();
    tr = 1; dbg = 1; hlt = 0; lsu = 0; exc = 0; slp = 0; pv = 1;
    ic = 1; en = 5'h1F; we = 0; wd = 0; pa = 32'h1000_0000;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    quiet();
    for (int i = 0; i < 5; i++) m[i] = 0;
    mo = 0; mpc = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 5; i++) check("R1 reset counter", dut_cnt(i), 32'h0);
    check("R1 reset overflow", {27'h0, ovf}, 32'h0);
    check("R1 reset pc", pcs, 32'hFFFF_FFFF);

    // R2: each gate alone blocks counting
    ic = 0; lsu = 0; exc = 0; slp = 0;
    tr = 0; tick(); check("R2 trace off holds", c_ovh, 32'h0);
    tr = 1; dbg = 0; tick(); check("R2 debug off holds", c_ovh, 32'h0);
    dbg = 1; en = 5'h1E; tick(); check("R2 enable off holds", c_ovh, 32'h0);
    en = 5'h1F; tick(); check("R2 all gates on counts", c_ovh, 32'h1);

    // R9: write beats a qualified increment in the same cycle
    we = 5'b00001; wd = 8'hFF; tick();
    check("R9 write beats increment", c_ovh, 32'h0000_00FF);
    check("R9 no pulse on write", {31'h0, ovf[0]}, 32'h0);
    we = 0; tick();
    check("R8 overhead wraps to zero", c_ovh, 32'h0);
    check("R8 overhead pulse", {31'h0, ovf[0]}, 32'h1);
    tick();
    check("R8 pulse lasts one cycle", {31'h0, ovf[0]}, 32'h0);

    // R8/R7: multi-count folded wrap, 254 + 2 -> 0
    we = 5'b10000; wd = 8'hFE; ic = 1; tick();
    we = 0; ic = 3; tick();
    check("R7 folded multi add wraps", c_fld, 32'h0);
    check("R8 folded wrap pulse", {31'h0, ovf[4]}, 32'h1);
    we = 5'b10000; wd = 8'hFF; ic = 1; tick();
    we = 0; ic = 2; tick();
    check("R8 folded single wrap", c_fld, 32'h0);

    // R10/R11 directed
    pa = 32'h2000_0007; hlt = 1; tick();
    check("R10 halted sentinel", pcs, 32'hFFFF_FFFF);
    hlt = 0; tick();
    check("R11 bit0 cleared", pcs, 32'h2000_0006);

    for (int n = 0; n < 4000; n++) begin
      tr  = ($urandom % 8) != 0;
      dbg = ($urandom % 8) != 0;
      hlt = ($urandom % 8) == 0;
      pv  = ($urandom % 4) != 0;
      ic  = 2'($urandom);
      lsu = 1'($urandom); exc = 1'($urandom); slp = 1'($urandom);
      en  = (($urandom % 4) == 0) ? 5'($urandom) : 5'h1F;
      we  = (($urandom % 16) == 0) ? 5'($urandom) : 5'h0;
      wd  = 8'($urandom);
      pa  = $urandom;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule